// File: doc/BRIEF.md
# Dual-Interface Volatile Buffer Page Mapper

This block sits between two access ports of a tag-style memory. It holds a non-volatile page array of 256 pages of 4 bytes and a 64-byte volatile buffer. A serial host addresses the memory in 16-byte blocks and always reaches the volatile buffer in a fixed block window. A contactless port reads four consecutive pages at a time. For each of those pages the block decides whether the bytes come from the buffer or from the non-volatile array.

That decision depends on four things: a mirror enable bit, a programmable mirror start page, a pass-through bit and a supply-present input. With mirroring on, the buffer covers 16 pages starting at the programmed page. With pass-through on, the buffer covers the top 16 pages of the page space instead. When the supply is absent, the buffer is treated as missing. Losing the supply also marks the buffer contents invalid, so the contents read as zero until the serial host writes them again.

Top module: `sram_mirror_mapper`

## Requirements
- R1: The serial host read data `h_rdata` is registered, one cycle after the address. Byte `h_byte` of host block F8h+k (k = 0..3) is buffer byte 16*k + `h_byte`. Host blocks 00h..3Fh address the non-volatile array at byte 16*`h_blk` + `h_byte`. Every other block reads zero and ignores writes.
- R2: A contactless read (`c_re` high with page p) raises `c_valid` on the next cycle. At the same time `c_rdata[8*(4*i+j) +: 8]` holds byte j of page (p+i) mod 256, for i and j from 0 to 3.
- R3: With both mirror and pass-through disabled, every contactless page returns the non-volatile data.
- R4: With mirror enabled and pass-through disabled, page q with start ≤ q < start+16 returns buffer bytes 4*(q-start)..4*(q-start)+3, provided the supply is present.
- R5: A start-page write with a value from 01h to 74h is accepted. Any other value is rejected: the previous start page is kept and the sticky `start_err` flag is set. After reset the start page is 01h and `start_err` is 0.
- R6: While `vcc_ok` is low, neither the mirror nor pass-through maps the buffer, and every contactless page returns non-volatile data.
- R7: With pass-through enabled and the supply present, pages F0h..FFh return buffer page (q-F0h), whatever the start page is. Pass-through takes precedence over the mirror, so the mirror window maps nothing while pass-through is on.
- R8: Reset clears the mirror and pass-through enables. The non-volatile array keeps its contents across reset.
- R9: Each of the four pages in a response is mapped on its own, so one response can mix buffer pages and non-volatile pages.
- R10: When a host buffer write and a contactless read touch the same buffer byte in the same cycle, the read returns the value held before the write, and the write still takes effect.
- R11: When `vcc_ok` goes low, or on reset, every buffer byte becomes invalid. Host buffer writes are ignored while `vcc_ok` is low. An invalid byte reads as zero on both ports until the host writes it while the supply is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| vcc_ok | input | 1 | Supply-present flag for the volatile buffer |
| cfg_we | input | 1 | Write strobe for the two mode bits |
| cfg_mirror_en | input | 1 | Mirror enable value to write |
| cfg_pthru_en | input | 1 | Pass-through enable value to write |
| start_we | input | 1 | Write strobe for the mirror start page |
| start_page | input | 8 | Requested mirror start page |
| mirror_en | output | 1 | Current mirror enable bit |
| pthru_en | output | 1 | Current pass-through enable bit |
| start_q | output | 8 | Current mirror start page |
| start_err | output | 1 | Sticky flag for a rejected start page |
| h_we | input | 1 | Serial host byte write strobe |
| h_blk | input | 8 | Serial host block address |
| h_byte | input | 4 | Byte within the 16-byte block |
| h_wdata | input | 8 | Serial host write data |
| h_rdata | output | 8 | Serial host read data, registered |
| c_re | input | 1 | Contactless read request |
| c_page | input | 8 | First page of the contactless read |
| c_valid | output | 1 | Contactless response valid |
| c_rdata | output | 128 | Four-page contactless response |

## Verification
The hardest cases to reach are the responses that straddle a window edge, where one 16-byte response mixes buffer pages and non-volatile pages. The stimulus reaches them by moving the start page to 20h and then to the top legal value 74h, and by reading at pages two below the window start and two below its end. The bench reads F0h with pass-through on, and reads page FEh so the response wraps around the page space. Supply loss is driven while both mappings are armed. The buffer is then read back after the supply returns, before and after a single byte is rewritten. A same-cycle host write and contactless read are aimed at one buffer byte.

// File: rtl/smm_pkg.sv
package smm_pkg;
  localparam int PAGE_BYTES  = 4;
  localparam int BLOCK_BYTES = 16;
  localparam logic [7:0] START_MIN    = 8'h01;
  localparam logic [7:0] START_MAX    = 8'h74;
  localparam logic [7:0] START_RESET  = 8'h01;
  localparam logic [7:0] PT_BASE_PAGE = 8'hF0;
  localparam logic [7:0] HOST_BUF_BLK = 8'hF8;
endpackage

// File: rtl/smm_ctrl.sv
module smm_ctrl
  import smm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_mirror_en,
  input  logic       cfg_pthru_en,
  input  logic       start_we,
  input  logic [7:0] start_page,
  output logic       mirror_en,
  output logic       pthru_en,
  output logic [7:0] start_q,
  output logic       start_err
);
  logic       mir_q, mir_d, pt_q, pt_d, err_q, err_d;
  logic [7:0] st_q, st_d;
  logic       legal;

  assign legal = (start_page >= START_MIN) && (start_page <= START_MAX);

  always_comb begin
    mir_d = mir_q;
    pt_d  = pt_q;
    st_d  = st_q;
    err_d = err_q;
    if (cfg_we) begin
      mir_d = cfg_mirror_en;
      pt_d  = cfg_pthru_en;
    end
    if (start_we) begin
      if (legal) st_d  = start_page;
      else       err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mir_q <= 1'b0;
      pt_q  <= 1'b0;
      st_q  <= START_RESET;
      err_q <= 1'b0;
    end else begin
      mir_q <= mir_d;
      pt_q  <= pt_d;
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign mirror_en = mir_q;
  assign pthru_en  = pt_q;
  assign start_q   = st_q;
  assign start_err = err_q;

  // R5
  start_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q >= START_MIN) && (st_q <= START_MAX));
  // R5
  start_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_we && !legal) |=> ($stable(st_q) && err_q));
  // R5
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_we && legal) |=> (st_q == $past(start_page)));
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/smm_buffer.sv
module smm_buffer #(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vcc_ok,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [7:0]               wr_data,
  output logic [DEPTH*8-1:0]       view
);
  logic [7:0]       mem_q [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;
  logic             wr_ok;

  assign wr_ok = wr_en && vcc_ok;

  always_comb begin
    vld_d = vld_q;
    if (!vcc_ok)    vld_d = '0;
    else if (wr_ok) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wr_idx] <= wr_data;
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_view
    assign view[gi*8 +: 8] = vld_q[gi] ? mem_q[gi] : 8'h00;
  end

  // R11
  supply_loss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok |=> (view == '0));
  // R11
  write_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && vcc_ok) |=> (view[wr_idx_past*8 +: 8] == $past(wr_data)));

  logic [$clog2(DEPTH)-1:0] wr_idx_past;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_idx_past <= '0;
    else        wr_idx_past <= wr_idx;
  end
endmodule

// File: rtl/smm_page_map.sv
module smm_page_map
  import smm_pkg::*;
#(
  parameter int BUF_PAGES = 16
) (
  input  logic       vcc_ok,
  input  logic       mirror_en,
  input  logic       pthru_en,
  input  logic [7:0] start,
  input  logic [7:0] page,
  output logic       use_buf,
  output logic [$clog2(BUF_PAGES)-1:0] buf_page
);
  localparam int BPW = $clog2(BUF_PAGES);
  logic [7:0] ofs;
  logic       hit_pt, hit_mr;

  assign ofs    = page - start;
  assign hit_pt = vcc_ok && pthru_en && (page >= PT_BASE_PAGE);
  assign hit_mr = vcc_ok && mirror_en && !pthru_en && (page >= start)
                  && (ofs < 8'(BUF_PAGES));

  always_comb begin
    use_buf  = hit_pt || hit_mr;
    buf_page = hit_pt ? BPW'(page - PT_BASE_PAGE) : ofs[BPW-1:0];
  end
endmodule

// File: rtl/sram_mirror_mapper.sv
module sram_mirror_mapper
  import smm_pkg::*;
#(
  parameter int BUF_PAGES = 16,
  parameter int RSP_PAGES = 4,
  parameter int EE_PAGES  = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vcc_ok,
  input  logic         cfg_we,
  input  logic         cfg_mirror_en,
  input  logic         cfg_pthru_en,
  input  logic         start_we,
  input  logic [7:0]   start_page,
  output logic         mirror_en,
  output logic         pthru_en,
  output logic [7:0]   start_q,
  output logic         start_err,
  input  logic         h_we,
  input  logic [7:0]   h_blk,
  input  logic [3:0]   h_byte,
  input  logic [7:0]   h_wdata,
  output logic [7:0]   h_rdata,
  input  logic         c_re,
  input  logic [7:0]   c_page,
  output logic         c_valid,
  output logic [127:0] c_rdata
);
  localparam int BUF_BYTES = BUF_PAGES * PAGE_BYTES;
  localparam int BUF_AW    = $clog2(BUF_BYTES);
  localparam int BPW       = $clog2(BUF_PAGES);
  localparam int EE_BYTES  = EE_PAGES * PAGE_BYTES;
  localparam int EE_AW     = $clog2(EE_BYTES);
  localparam int EE_BLKS   = EE_BYTES / BLOCK_BYTES;
  localparam int HB_W      = $clog2(BUF_BYTES / BLOCK_BYTES);
  localparam int RSP_W     = RSP_PAGES * PAGE_BYTES * 8;

  logic [7:0]           ee_mem [EE_BYTES];
  logic [BUF_BYTES*8-1:0] buf_view;
  logic                 h_in_buf, h_in_ee;
  logic [EE_AW-1:0]     h_ee_idx;
  logic [BUF_AW-1:0]    h_buf_idx;
  logic [7:0]           h_rdata_d, h_rdata_q;
  logic [RSP_W-1:0]     rsp_d, ee_rsp, rsp_q;
  logic                 valid_q;

  smm_ctrl u_ctrl (
    .clk, .rst_n, .cfg_we, .cfg_mirror_en, .cfg_pthru_en,
    .start_we, .start_page, .mirror_en, .pthru_en, .start_q, .start_err
  );

  assign h_in_buf  = (h_blk >> HB_W) == (HOST_BUF_BLK >> HB_W);
  assign h_in_ee   = 32'(h_blk) < EE_BLKS;
  assign h_ee_idx  = EE_AW'({h_blk, h_byte});
  assign h_buf_idx = BUF_AW'({h_blk, h_byte});

  smm_buffer #(.DEPTH(BUF_BYTES)) u_buf (
    .clk, .rst_n, .vcc_ok,
    .wr_en  (h_we && h_in_buf),
    .wr_idx (h_buf_idx),
    .wr_data(h_wdata),
    .view   (buf_view)
  );

  always_ff @(posedge clk) begin
    if (h_we && h_in_ee) ee_mem[h_ee_idx] <= h_wdata;
  end

  always_comb begin
    if (h_in_buf)     h_rdata_d = buf_view[h_buf_idx*8 +: 8];
    else if (h_in_ee) h_rdata_d = ee_mem[h_ee_idx];
    else              h_rdata_d = 8'h00;
  end

  for (genvar gi = 0; gi < RSP_PAGES; gi++) begin : g_page
    logic [7:0]     pg;
    logic           sel_buf;
    logic [BPW-1:0] bpg;
    assign pg = c_page + 8'(gi);
    smm_page_map #(.BUF_PAGES(BUF_PAGES)) u_map (
      .vcc_ok, .mirror_en, .pthru_en, .start(start_q),
      .page(pg), .use_buf(sel_buf), .buf_page(bpg)
    );
    for (genvar gj = 0; gj < PAGE_BYTES; gj++) begin : g_byte
      localparam int POS = (gi * PAGE_BYTES + gj) * 8;
      logic [BUF_AW-1:0] bidx;
      assign bidx = BUF_AW'({bpg, 2'(gj)});
      assign ee_rsp[POS +: 8] = ee_mem[EE_AW'({pg, 2'(gj)})];
      assign rsp_d[POS +: 8]  = sel_buf ? buf_view[bidx*8 +: 8] : ee_rsp[POS +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      h_rdata_q <= 8'h00;
    end else begin
      valid_q   <= c_re;
      h_rdata_q <= h_rdata_d;
    end
  end

  always_ff @(posedge clk) begin
    if (c_re) rsp_q <= rsp_d;
  end

  assign h_rdata = h_rdata_q;
  assign c_valid = valid_q;
  assign c_rdata = 128'(rsp_q);

  // R2
  rsp_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_re |=> c_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c_re |=> !c_valid);
  // R3 / R6
  ee_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_re && (!vcc_ok || (!mirror_en && !pthru_en))) |=> (rsp_q == $past(ee_rsp)));
  // R7
  pthru_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_re && vcc_ok && pthru_en && (c_page == PT_BASE_PAGE))
      |=> (rsp_q == $past(buf_view[RSP_W-1:0])));
endmodule

// File: tb/tb_sram_mirror_mapper.sv
`timescale 1ns/1ps
module tb_sram_mirror_mapper;
  logic clk = 1'b0;
  logic rst_n, vcc_ok, cfg_we, cfg_mirror_en, cfg_pthru_en, start_we;
  logic [7:0] start_page, start_q, h_blk, h_wdata, h_rdata, c_page;
  logic [3:0] h_byte;
  logic mirror_en, pthru_en, start_err, h_we, c_re, c_valid;
  logic [127:0] c_rdata;

  int checks = 0;
  int errors = 0;

  logic [7:0] ee_m [1024];
  logic [7:0] buf_m [64];
  bit         bv [64];
  bit         m_mir, m_pt, m_vcc, m_err;
  logic [7:0] m_start;

  always #2.5 clk = ~clk;

  sram_mirror_mapper dut (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bufb(input int i);
    return bv[i] ? buf_m[i] : 8'h00;
  endfunction

  function automatic logic [127:0] exp_rsp(input logic [7:0] p);
    logic [127:0] r;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] q = p + 8'(i);
      logic [7:0] o = q - m_start;
      for (int j = 0; j < 4; j++) begin
        if (m_vcc && m_pt && q >= 8'hF0)
          r[(4*i+j)*8 +: 8] = bufb(int'(q - 8'hF0) * 4 + j);
        else if (m_vcc && m_mir && !m_pt && q >= m_start && o < 8'd16)
          r[(4*i+j)*8 +: 8] = bufb(int'(o) * 4 + j);
        else
          r[(4*i+j)*8 +: 8] = ee_m[int'(q) * 4 + j];
      end
    end
    return r;
  endfunction

  task automatic hw(input logic [7:0] b, input logic [3:0] y, input logic [7:0] d);
    h_we = 1'b1; h_blk = b; h_byte = y; h_wdata = d;
    @(negedge clk);
    h_we = 1'b0;
    if (b < 8'h40) ee_m[int'(b) * 16 + int'(y)] = d;
    else if (b >= 8'hF8 && b <= 8'hFB && m_vcc) begin
      buf_m[int'(b - 8'hF8) * 16 + int'(y)] = d;
      bv[int'(b - 8'hF8) * 16 + int'(y)] = 1'b1;
    end
  endtask

  task automatic hr(input logic [7:0] b, input logic [3:0] y, input logic [7:0] e, input string req);
    h_blk = b; h_byte = y;
    @(negedge clk);
    chk(h_rdata == e, req, 128'(h_rdata), 128'(e));
  endtask

  task automatic cr(input logic [7:0] p, input string req);
    logic [127:0] e;
    e = exp_rsp(p);
    c_re = 1'b1; c_page = p;
    @(negedge clk);
    c_re = 1'b0;
    chk(c_valid && c_rdata == e, req, c_rdata, e);
  endtask

  task automatic set_mode(input bit mir, input bit pt);
    cfg_we = 1'b1; cfg_mirror_en = mir; cfg_pthru_en = pt;
    @(negedge clk);
    cfg_we = 1'b0; m_mir = mir; m_pt = pt;
  endtask

  task automatic set_start(input logic [7:0] s);
    start_we = 1'b1; start_page = s;
    @(negedge clk);
    start_we = 1'b0;
    if (s >= 8'h01 && s <= 8'h74) m_start = s; else m_err = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_mir = 0; m_pt = 0; m_start = 8'h01; m_err = 0;
    for (int i = 0; i < 64; i++) bv[i] = 0;
  endtask

  task automatic t_reset_state();
    chk(!mirror_en && !pthru_en, "R8", {mirror_en, pthru_en}, 0);
    chk(start_q == 8'h01 && !start_err, "R5", {start_q, start_err}, {8'h01, 1'b0});
    chk(!c_valid, "R2", c_valid, 0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < 1024; a++)
      hw(8'(a / 16), 4'(a % 16), 8'(a * 7 + a / 256) ^ 8'h5A);
    for (int i = 0; i < 64; i++)
      hw(8'hF8 + 8'(i / 16), 4'(i % 16), 8'hC0 ^ 8'(i * 3));
    hr(8'h05, 4'h3, ee_m[16*5+3], "R1");
    hr(8'hF9, 4'h2, buf_m[18], "R1");
    hr(8'hFB, 4'hF, buf_m[63], "R1");
    hw(8'h80, 4'h0, 8'hEE);
    hr(8'h80, 4'h0, 8'h00, "R1");
  endtask

  task automatic t_plain();
    cr(8'h00, "R3");
    cr(8'hF0, "R3");
    cr(8'hFE, "R2");
    cr(8'h20, "R3");
  endtask

  task automatic t_mirror();
    set_start(8'h20);
    set_mode(1'b1, 1'b0);
    cr(8'h20, "R4");
    cr(8'h1E, "R9");
    cr(8'h2E, "R9");
    cr(8'h30, "R4");
  endtask

  task automatic t_start_range();
    set_start(8'h75);
    chk(start_q == 8'h20 && start_err, "R5", {start_q, start_err}, {8'h20, 1'b1});
    set_start(8'h00);
    chk(start_q == 8'h20, "R5", start_q, 8'h20);
    set_start(8'h74);
    chk(start_q == 8'h74 && start_err, "R5", {start_q, start_err}, {8'h74, 1'b1});
    cr(8'h74, "R4");
    cr(8'h82, "R9");
  endtask

  task automatic t_pthru();
    set_mode(1'b1, 1'b1);
    cr(8'hF0, "R7");
    cr(8'hFC, "R7");
    cr(8'h74, "R7");
    cr(8'hEE, "R9");
  endtask

  task automatic t_collision();
    logic [127:0] e;
    e = exp_rsp(8'hF0);
    c_re = 1'b1; c_page = 8'hF0;
    hw(8'hF8, 4'h5, 8'h3D);
    c_re = 1'b0;
    chk(c_rdata == e, "R10", c_rdata, e);
    cr(8'hF0, "R10");
  endtask

  task automatic t_supply();
    vcc_ok = 1'b0; m_vcc = 0;
    for (int i = 0; i < 64; i++) bv[i] = 0;
    @(negedge clk);
    cr(8'hF0, "R6");
    set_mode(1'b1, 1'b0);
    cr(8'h74, "R6");
    hw(8'hF8, 4'h1, 8'h77);
    hr(8'hF8, 4'h1, 8'h00, "R11");
    vcc_ok = 1'b1; m_vcc = 1;
    @(negedge clk);
    cr(8'h74, "R11");
    hw(8'hF8, 4'h1, 8'h99);
    cr(8'h74, "R11");
    hr(8'hF8, 4'h2, 8'h00, "R11");
  endtask

  task automatic t_por();
    do_reset();
    t_reset_state();
    cr(8'h74, "R8");
    hr(8'hF8, 4'h1, 8'h00, "R11");
  endtask

  initial begin
    rst_n = 0; vcc_ok = 1; cfg_we = 0; cfg_mirror_en = 0; cfg_pthru_en = 0;
    start_we = 0; start_page = 0; h_we = 0; h_blk = 0; h_byte = 0; h_wdata = 0;
    c_re = 0; c_page = 0; m_vcc = 1;
    @(negedge clk);
    do_reset();
    t_reset_state();
    t_fill();
    t_plain();
    t_mirror();
    t_start_range();
    t_pthru();
    t_collision();
    t_supply();
    t_por();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule